// File: doc/BRIEF.md
# Work Queue Producer with Doorbell

This block keeps the producer-side bookkeeping of one circular descriptor queue shared between a host and a DMA engine. The host posts descriptors of varying length. Each descriptor uses one queue entry, and its data takes a whole number of 64-byte slots. The block tracks four values: a producer index that counts entries, a producer index that counts slots, a consumer index, and the number of entries in use. From these it derives full, empty and free-space status. One entry is always left empty, so that a full queue can be told apart from an empty one.

When the host rings the queue, the block sends a single-cycle doorbell strobe toward the DMA engine. The strobe carries a packed 32-bit word holding the queue identifier, a priority flag and a producer increment. Two per-queue flags can be set, cleared and read back: an error flag and a doorbell-mute flag. While the mute flag is set, ring requests are held back and their increments are summed. When the flag is cleared, the sum goes out as one doorbell.

Top module: `wq_producer`

## Requirements
- R1: While reset is held, every index and the in-use count are zero, `empty` is 1, `full` and `q_err` are 0, both flags are clear and `db_valid` is 0.
- R2: `full` is 1 exactly when `in_use` equals DEPTH-1. `empty` is 1 exactly when `in_use` is 0. `avail` always equals DEPTH-1-`in_use`.
- R3: An accepted produce raises `in_use` by one and advances `pidx` by one, wrapping from DEPTH-1 to 0. The new values are visible after the next clock edge.
- R4: An accepted produce advances `slot_pidx` by ceil(`prod_len16`*16/64) and wraps modulo DEPTH*SLOTS. A length of 0 leaves it unchanged.
- R5: An accepted consume lowers `in_use` by one and advances `cidx` by one, wrapping from DEPTH-1 to 0.
- R6: A produce while full, or a consume while empty, changes no index or count. Either one raises `q_err` for exactly the one cycle after the edge.
- R7: An accepted produce and an accepted consume in the same cycle both move their indices, and `in_use` stays unchanged.
- R8: A ring while the mute flag is clear gives `db_valid`=1 for one cycle after the edge. The word is laid out as `qid` in bits [31:15], `ring_prio` in bit 14 and the increment in bits [13:0].
- R9: While the mute flag is set, a ring gives no doorbell. The increments are summed with saturation at 16383, and the priority bits are ORed together.
- R10: Clearing the mute flag (without setting it in the same cycle) gives one doorbell carrying the summed increment and priority. It gives none if the sum is zero. A ring in that same cycle joins the sum.
- R11: `err_flag` and `dboff_flag` follow their set and clear inputs one edge later. Set wins when both are asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qid | input | 17 | Queue identifier placed in the doorbell word |
| prod_req | input | 1 | Post one descriptor |
| prod_len16 | input | LEN_W | Descriptor length in 16-byte units |
| cons_req | input | 1 | Retire one descriptor |
| ring_req | input | 1 | Request a doorbell |
| ring_prio | input | 1 | Priority flag for the doorbell |
| ring_inc | input | 14 | Producer increment for the doorbell |
| err_set | input | 1 | Set the error flag |
| err_clr | input | 1 | Clear the error flag |
| dboff_set | input | 1 | Set the doorbell-mute flag |
| dboff_clr | input | 1 | Clear the doorbell-mute flag |
| pidx | output | $clog2(DEPTH) | Entry producer index |
| slot_pidx | output | $clog2(DEPTH*SLOTS) | Slot producer index |
| cidx | output | $clog2(DEPTH) | Consumer index |
| in_use | output | $clog2(DEPTH) | Occupied entries |
| avail | output | $clog2(DEPTH) | Free entries |
| full | output | 1 | Queue full |
| empty | output | 1 | Queue empty |
| q_err | output | 1 | One-cycle pulse on a refused produce or consume |
| err_flag | output | 1 | Error flag readback |
| dboff_flag | output | 1 | Doorbell-mute flag readback |
| db_valid | output | 1 | Doorbell strobe |
| db_word | output | 32 | Packed doorbell word |

## Verification
The bench builds the block with DEPTH=8, SLOTS=5 and LEN_W=6. With 8 entries the queue fills after seven posts and the entry indices wrap within a few dozen cycles. With a slot modulus of 40 and at most 16 slots per descriptor, the slot index wraps at many different offsets, including exact landings on the modulus. Ring increments near 14 bits reach the saturation limit within three muted rings.

// File: rtl/wqp_pkg.sv
package wqp_pkg;
  localparam int DB_QID_W       = 17;
  localparam int DB_INC_W       = 14;
  localparam int SLOT_BYTES     = 64;
  localparam int LEN_UNIT_BYTES = 16;

  // number of whole slots a descriptor of len16 units occupies
  function automatic int unsigned slots_for_len(input int unsigned len16);
    return (len16 * LEN_UNIT_BYTES + SLOT_BYTES - 1) / SLOT_BYTES;
  endfunction

  // saturating add of two doorbell increments
  function automatic logic [DB_INC_W-1:0] sat_inc(input logic [DB_INC_W-1:0] a,
                                                  input logic [DB_INC_W-1:0] b);
    logic [DB_INC_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[DB_INC_W] ? {DB_INC_W{1'b1}} : s[DB_INC_W-1:0];
  endfunction

  // doorbell layout: queue id high, priority, increment low
  function automatic logic [31:0] pack_db(input logic [DB_QID_W-1:0] q,
                                          input logic p,
                                          input logic [DB_INC_W-1:0] inc);
    return {q, p, inc};
  endfunction
endpackage

// File: rtl/wqp_wrap_idx.sv
module wqp_wrap_idx #(
  parameter int MOD = 16,
  parameter int W   = $clog2(MOD)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] step,
  output logic [W-1:0] idx
);
  localparam logic [W:0] MOD_V = (W+1)'(MOD);

  logic [W-1:0] idx_q;
  logic [W:0]   sum;
  logic [W:0]   wrapped;

  always_comb begin
    sum     = {1'b0, idx_q} + {1'b0, step};
    wrapped = (sum >= MOD_V) ? (sum - MOD_V) : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx_q <= '0;
    else if (adv) idx_q <= wrapped[W-1:0];
  end

  assign idx = idx_q;
endmodule

// File: rtl/wqp_occupancy.sv
module wqp_occupancy #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prod_req,
  input  logic          cons_req,
  output logic          prod_fire,
  output logic          cons_fire,
  output logic [CW-1:0] in_use,
  output logic [CW-1:0] avail,
  output logic          full,
  output logic          empty,
  output logic          q_err
);
  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

  logic [CW-1:0] cnt_q;
  logic          err_q;
  logic          refuse;

  assign full      = (cnt_q == LAST);
  assign empty     = (cnt_q == '0);
  assign prod_fire = prod_req && !full;
  assign cons_fire = cons_req && !empty;
  assign refuse    = (prod_req && full) || (cons_req && empty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= refuse;
      if (prod_fire && !cons_fire)      cnt_q <= cnt_q + 1'b1;
      else if (cons_fire && !prod_fire) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign in_use = cnt_q;
  assign avail  = LAST - cnt_q;
  assign q_err  = err_q;
endmodule

// File: rtl/wqp_doorbell.sv
module wqp_doorbell
  import wqp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DB_QID_W-1:0] qid,
  input  logic                ring_req,
  input  logic                ring_prio,
  input  logic [DB_INC_W-1:0] ring_inc,
  input  logic                err_set,
  input  logic                err_clr,
  input  logic                dboff_set,
  input  logic                dboff_clr,
  output logic                err_flag,
  output logic                dboff_flag,
  output logic                db_fire,
  output logic                db_valid,
  output logic [31:0]         db_word
);
  logic                err_q, off_q;
  logic [DB_INC_W-1:0] pend_q;
  logic                pend_prio_q;
  logic [DB_INC_W-1:0] total;
  logic                tprio;
  logic                release_now;
  logic                v_q;
  logic [31:0]         w_q;

  always_comb begin
    total       = sat_inc(pend_q, ring_req ? ring_inc : '0);
    tprio       = pend_prio_q | (ring_req & ring_prio);
    release_now = off_q && dboff_clr && !dboff_set;
    if (!off_q) db_fire = ring_req;
    else        db_fire = release_now && (total != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q       <= 1'b0;
      off_q       <= 1'b0;
      pend_q      <= '0;
      pend_prio_q <= 1'b0;
      v_q         <= 1'b0;
      w_q         <= '0;
    end else begin
      if (err_set)        err_q <= 1'b1;
      else if (err_clr)   err_q <= 1'b0;
      if (dboff_set)      off_q <= 1'b1;
      else if (dboff_clr) off_q <= 1'b0;
      if (!off_q || release_now) begin
        pend_q      <= '0;
        pend_prio_q <= 1'b0;
      end else begin
        pend_q      <= total;
        pend_prio_q <= tprio;
      end
      v_q <= db_fire;
      if (db_fire) w_q <= pack_db(qid, tprio, total);
    end
  end

  assign err_flag   = err_q;
  assign dboff_flag = off_q;
  assign db_valid   = v_q;
  assign db_word    = w_q;
endmodule

// File: rtl/wq_producer.sv
module wq_producer
  import wqp_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int SLOTS = 5,
  parameter int LEN_W = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int SMOD = DEPTH * SLOTS,
  localparam int SW   = $clog2(SMOD)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DB_QID_W-1:0] qid,
  input  logic                prod_req,
  input  logic [LEN_W-1:0]    prod_len16,
  input  logic                cons_req,
  input  logic                ring_req,
  input  logic                ring_prio,
  input  logic [DB_INC_W-1:0] ring_inc,
  input  logic                err_set,
  input  logic                err_clr,
  input  logic                dboff_set,
  input  logic                dboff_clr,
  output logic [IW-1:0]       pidx,
  output logic [SW-1:0]       slot_pidx,
  output logic [IW-1:0]       cidx,
  output logic [IW-1:0]       in_use,
  output logic [IW-1:0]       avail,
  output logic                full,
  output logic                empty,
  output logic                q_err,
  output logic                err_flag,
  output logic                dboff_flag,
  output logic                db_valid,
  output logic [31:0]         db_word
);
  // internal events brought out for the checker
  logic          prod_fire;
  logic          cons_fire;
  logic          db_fire;
  logic [SW-1:0] slot_step;

  assign slot_step = SW'(slots_for_len(32'(prod_len16)));

  wqp_occupancy #(.DEPTH(DEPTH), .CW(IW)) u_occ (
    .clk(clk), .rst_n(rst_n), .prod_req(prod_req), .cons_req(cons_req),
    .prod_fire(prod_fire), .cons_fire(cons_fire), .in_use(in_use),
    .avail(avail), .full(full), .empty(empty), .q_err(q_err)
  );

  wqp_wrap_idx #(.MOD(DEPTH), .W(IW)) u_pidx (
    .clk(clk), .rst_n(rst_n), .adv(prod_fire), .step(IW'(1)), .idx(pidx)
  );

  wqp_wrap_idx #(.MOD(SMOD), .W(SW)) u_spidx (
    .clk(clk), .rst_n(rst_n), .adv(prod_fire), .step(slot_step), .idx(slot_pidx)
  );

  wqp_wrap_idx #(.MOD(DEPTH), .W(IW)) u_cidx (
    .clk(clk), .rst_n(rst_n), .adv(cons_fire), .step(IW'(1)), .idx(cidx)
  );

  wqp_doorbell u_db (
    .clk(clk), .rst_n(rst_n), .qid(qid), .ring_req(ring_req),
    .ring_prio(ring_prio), .ring_inc(ring_inc), .err_set(err_set),
    .err_clr(err_clr), .dboff_set(dboff_set), .dboff_clr(dboff_clr),
    .err_flag(err_flag), .dboff_flag(dboff_flag), .db_fire(db_fire),
    .db_valid(db_valid), .db_word(db_word)
  );
endmodule

// File: rtl/wqp_chk.sv
module wqp_chk #(
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          prod_req,
  input logic          cons_req,
  input logic          ring_req,
  input logic          dboff_clr,
  input logic          full,
  input logic          empty,
  input logic [IW-1:0] in_use,
  input logic          q_err,
  input logic          dboff_flag,
  input logic          db_valid,
  input logic          db_fire
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full && prod_req && !cons_req |=> in_use == $past(in_use)); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    empty && cons_req && !prod_req |=> empty); // R6
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_req && full) || (cons_req && empty) |=> q_err); // R6
  AST_PROD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    prod_req && !full && !cons_req |=> in_use == $past(in_use) + 1'b1); // R3
  AST_CONS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cons_req && !empty && !prod_req |=> in_use == $past(in_use) - 1'b1); // R5
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    prod_req && cons_req && !full && !empty |=> in_use == $past(in_use)); // R7
  AST_RING_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ring_req && !dboff_flag |=> db_valid); // R8
  AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    dboff_flag && !dboff_clr |=> !db_valid); // R9
  AST_STROBE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    db_fire |=> db_valid); // R10
endmodule

bind wq_producer wqp_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .prod_req(prod_req), .cons_req(cons_req),
  .ring_req(ring_req), .dboff_clr(dboff_clr), .full(full), .empty(empty),
  .in_use(in_use), .q_err(q_err), .dboff_flag(dboff_flag),
  .db_valid(db_valid), .db_fire(db_fire)
);

// File: tb/sim_wq_producer.sv
`timescale 1ns/1ps
module sim_wq_producer;
  localparam int D = 8;
  localparam int S = 5;
  localparam int LW = 6;
  localparam int IW = $clog2(D);
  localparam int SW = $clog2(D * S);
  localparam logic [16:0] QID = 17'h1ABCD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prod_req = 0, cons_req = 0, ring_req = 0, ring_prio = 0;
  logic [LW-1:0] prod_len16 = '0;
  logic [13:0] ring_inc = '0;
  logic err_set = 0, err_clr = 0, dboff_set = 0, dboff_clr = 0;
  logic [IW-1:0] pidx, cidx, in_use, avail;
  logic [SW-1:0] slot_pidx;
  logic full, empty, q_err, err_flag, dboff_flag, db_valid;
  logic [31:0] db_word;

  always #5 clk = ~clk;

  wq_producer #(.DEPTH(D), .SLOTS(S), .LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .qid(QID), .prod_req(prod_req),
    .prod_len16(prod_len16), .cons_req(cons_req), .ring_req(ring_req),
    .ring_prio(ring_prio), .ring_inc(ring_inc), .err_set(err_set),
    .err_clr(err_clr), .dboff_set(dboff_set), .dboff_clr(dboff_clr),
    .pidx(pidx), .slot_pidx(slot_pidx), .cidx(cidx), .in_use(in_use),
    .avail(avail), .full(full), .empty(empty), .q_err(q_err),
    .err_flag(err_flag), .dboff_flag(dboff_flag), .db_valid(db_valid),
    .db_word(db_word)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_p, m_s, m_c, m_n, m_pend;
  bit m_pprio, m_err, m_off, m_dbv, m_qerr;
  longint m_dbw;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_p = 0; m_s = 0; m_c = 0; m_n = 0; m_pend = 0;
    m_pprio = 0; m_err = 0; m_off = 0; m_dbv = 0; m_qerr = 0; m_dbw = 0;
  endtask

  task automatic model_step();
    bit pf, cf, fire;
    int tot;
    bit tp;
    pf = prod_req && (m_n != D - 1);
    cf = cons_req && (m_n != 0);
    m_qerr = (prod_req && m_n == D - 1) || (cons_req && m_n == 0);
    if (pf) begin
      m_p = (m_p + 1) % D;
      m_s = (m_s + (int'(prod_len16) * 16 + 63) / 64) % (D * S);
    end
    if (cf) m_c = (m_c + 1) % D;
    m_n = m_n + int'(pf) - int'(cf);
    tot = m_pend + (ring_req ? int'(ring_inc) : 0);
    if (tot > 16383) tot = 16383;
    tp = m_pprio | (ring_req & ring_prio);
    fire = 0;
    if (!m_off) begin
      fire = ring_req;
      m_pend = 0; m_pprio = 0;
    end else if (dboff_clr && !dboff_set) begin
      fire = (tot != 0);
      m_pend = 0; m_pprio = 0;
    end else begin
      m_pend = tot; m_pprio = tp;
    end
    m_dbv = fire;
    if (fire) m_dbw = (longint'(QID) << 15) | (longint'(tp) << 14) | longint'(tot);
    if (err_set) m_err = 1; else if (err_clr) m_err = 0;
    if (dboff_set) m_off = 1; else if (dboff_clr) m_off = 0;
  endtask

  task automatic compare_all();
    chk("R3 pidx", pidx, m_p);
    chk("R4 slot_pidx", slot_pidx, m_s);
    chk("R5 cidx", cidx, m_c);
    chk("R2 in_use", in_use, m_n);
    chk("R2 avail", avail, D - 1 - m_n);
    chk("R2 full", full, m_n == D - 1);
    chk("R2 empty", empty, m_n == 0);
    chk("R6 q_err", q_err, m_qerr);
    chk("R11 err_flag", err_flag, m_err);
    chk("R11 dboff_flag", dboff_flag, m_off);
    chk("R8 db_valid", db_valid, m_dbv);
    if (m_dbv) chk("R8 db_word", db_word, m_dbw);
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    prod_req = 0; cons_req = 0; ring_req = 0; ring_prio = 0; ring_inc = '0;
    err_set = 0; err_clr = 0; dboff_set = 0; dboff_clr = 0; prod_len16 = '0;
  endtask

  task automatic produce(input int len);
    idle(); prod_req = 1; prod_len16 = LW'(len); step();
  endtask

  task automatic consume();
    idle(); cons_req = 1; step();
  endtask

  task automatic ring(input int inc, input bit pr);
    idle(); ring_req = 1; ring_inc = 14'(inc); ring_prio = pr; step();
  endtask

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", wd);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    compare_all();
    chk("R1 db_valid in reset", db_valid, 0);
    rst_n = 1;
    @(negedge clk);

    // fill with assorted lengths (R3, R4)
    produce(0); produce(1); produce(4); produce(5);
    produce(17); produce(63); produce(8);
    chk("R2 full after seven", full, 1);
    produce(12);                       // refused while full
    chk("R6 produce while full flags q_err", q_err, 1);
    chk("R6 produce while full keeps pidx", pidx, 7);
    idle(); step();
    chk("R6 q_err one cycle", q_err, 0);

    // full: produce+consume -> only consume takes effect
    idle(); prod_req = 1; cons_req = 1; prod_len16 = 6'd3; step();
    chk("R6 full-refuse with consume", in_use, 6);
    // legal simultaneous pair
    idle(); prod_req = 1; cons_req = 1; prod_len16 = 6'd9; step();
    chk("R7 in_use unchanged", in_use, 6);

    // drain and underflow
    for (int i = 0; i < 6; i++) consume();
    chk("R2 empty after drain", empty, 1);
    consume();
    chk("R6 consume while empty flags q_err", q_err, 1);
    chk("R6 consume while empty keeps cidx", cidx, m_c);

    // wrap both indices repeatedly
    for (int i = 0; i < 30; i++) begin
      produce((i * 7) % 64);
      consume();
    end

    // doorbell while enabled
    ring(5, 1);
    chk("R8 strobe", db_valid, 1);
    chk("R8 word layout", db_word, {QID, 1'b1, 14'd5});
    idle(); step();
    chk("R8 single cycle", db_valid, 0);

    // muted accumulation with saturation
    idle(); dboff_set = 1; step();
    ring(10000, 0);
    chk("R9 muted no strobe", db_valid, 0);
    ring(9000, 1);
    ring(3, 0);
    chk("R9 still silent", db_valid, 0);
    idle(); dboff_clr = 1; step();
    chk("R10 release strobe", db_valid, 1);
    chk("R10 saturated word", db_word, {QID, 1'b1, 14'h3FFF});
    idle(); step();
    // release with nothing pending
    idle(); dboff_set = 1; step();
    idle(); dboff_clr = 1; step();
    chk("R10 empty release silent", db_valid, 0);
    // ring in same cycle as release
    idle(); dboff_set = 1; step();
    ring(2, 0);
    idle(); dboff_clr = 1; ring_req = 1; ring_inc = 14'd7; step();
    chk("R10 joint release", db_word, {QID, 1'b0, 14'd9});

    // flags: set wins
    idle(); err_set = 1; err_clr = 1; dboff_set = 1; dboff_clr = 1; step();
    chk("R11 err set wins", err_flag, 1);
    chk("R11 dboff set wins", dboff_flag, 1);
    idle(); err_clr = 1; dboff_clr = 1; step();
    chk("R11 err cleared", err_flag, 0);

    // random traffic against the model
    for (int i = 0; i < 1500; i++) begin
      idle();
      prod_req   = ($urandom % 3) != 0;
      cons_req   = ($urandom % 3) == 0;
      prod_len16 = LW'($urandom);
      ring_req   = ($urandom % 4) == 0;
      ring_prio  = $urandom % 2;
      ring_inc   = 14'($urandom);
      err_set    = ($urandom % 16) == 0;
      err_clr    = ($urandom % 16) == 0;
      dboff_set  = ($urandom % 12) == 0;
      dboff_clr  = ($urandom % 10) == 0;
      step();
    end
    idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule